// File: doc/BRIEF.md
# Automatic Baud Rate Detector with Echo

This block sits beside an asynchronous serial port and listens to its receive line while the port's receiver is still switched off. It waits for the first character of a two-character attention sequence. That sequence is "AT" in capitals or "at" in lower case. The block counts, in system clocks, how long the start bit of that first character stays low, and converts that count into a baud generator divisor for a receiver that oversamples sixteen times per bit.

The block then checks the rest of the sequence at the new rate. It samples the first character's data and stop bits, waits for the second character, and samples all of that character's bits. If both characters match in the same case, the detection is accepted. The block can then load the divisor into the port's baud generator and switch the receiver on. It can also send the two characters back out on the transmit line at the new rate, and it sets an interrupt flag that a mask input can hide. None of this needs the processor. A glitch, a line held low too long, a missing second character or a wrong character sends the block back to waiting for a new sequence.

Top module: `autobaud_det`

## Requirements
- R1: After reset, rx_en_o, baud_we_o and irq_o are 0, and tx_o follows uart_tx_i.
- R2: For a start-bit low time of N system clocks, the divisor is (N+8)/16 with the remainder dropped, which is N/16 rounded half up. baud_div_o takes this value on every accepted detection, even when prog_en_i is 0. Rates up to 921.6 kbaud can be detected at a 125 MHz clock.
- R3: When prog_en_i is 1, an accepted detection gives one single-cycle pulse on baud_we_o and sets rx_en_o. When prog_en_i is 0, neither happens. rx_en_o is cleared when arm_i goes from 0 to 1.
- R4: Both characters are sampled at the derived rate as 8N1 frames, LSB first, at mid-bit. Detection is accepted only for the byte pair 0x41 then 0x54, or the pair 0x61 then 0x74. Any other pair, a low stop bit or a high start bit rejects the sequence, and the block waits for a new one.
- R5: A low pulse shorter than MIN_W (default 16) clocks is ignored.
- R6: If the low time of the first start bit reaches ABORT_AT clocks, measurement stops without detecting. With the defaults, ABORT_AT is 16375. The block rearms once the line has gone high again.
- R7: When echo_en_i is 1, the first character and then the second are sent on tx_o as back-to-back 8N1 frames with a bit time of 16 times the divisor. Sending starts two clocks after detection. At all other times tx_o equals uart_tx_i.
- R8: An accepted detection sets an interrupt flag, and irq_ack_i clears it. irq_o is the flag ANDed with irq_en_i, so a flag set while masked shows up as soon as irq_en_i is raised.
- R9: The detector watches the line only while arm_i is 1. After an accepted detection it ignores the line until arm_i is taken low and then high again.
- R10: If no second start bit begins within GAP_BITS (default 16) bit times after the first character's stop sample, the sequence is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, asynchronous |
| uart_tx_i | input | 1 | Transmit line from the port's own transmitter |
| arm_i | input | 1 | Detector enable; a 0-to-1 change rearms the detector |
| prog_en_i | input | 1 | Allows writing the divisor and enabling the receiver |
| echo_en_i | input | 1 | Allows echoing the sequence on tx_o |
| irq_en_i | input | 1 | Interrupt mask, 1 = enabled |
| irq_ack_i | input | 1 | Clears the interrupt flag |
| tx_o | output | 1 | Transmit line after the echo mux |
| baud_div_o | output | DIV_W | Divisor from the last accepted detection |
| baud_we_o | output | 1 | One-cycle write strobe for the baud generator register |
| rx_en_o | output | 1 | Receiver enable |
| irq_o | output | 1 | Masked detection interrupt |

## Verification
The bench drives sequences whose low times round exactly or with a few clocks of error, at rates from 128 to 600 clocks per bit. A wrong rounding step would produce a divisor that is off by one. It sends a short glitch, a line held low past the abort limit, a first character with no second one, and mismatched pairs such as "AX" and "aT". A detector that failed to rearm after any of these would miss the valid sequence that follows, and one that was too loose would strobe the baud register for a bad pair. The bench also resends the sequence after a detection and while the detector is disarmed, decodes the echoed frames bit by bit, and watches on every clock that tx_o copies uart_tx_i, which toggles on its own, whenever echo is off.

// File: rtl/ab_pkg.sv
package ab_pkg;
   typedef enum logic [2:0] {
      ST_OFF,
      ST_HUNT,
      ST_MEAS,
      ST_CHAR1,
      ST_GAP,
      ST_CHAR2,
      ST_DONE
   } ab_state_t;

   localparam logic [7:0] FIRST_UP  = 8'h41;
   localparam logic [7:0] FIRST_LO  = 8'h61;
   localparam logic [7:0] SECOND_UP = 8'h54;
   localparam logic [7:0] SECOND_LO = 8'h74;
endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("ab_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= RESET_VAL;
         else        r <= d_i;
      end
      assign q_o = r;
   end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= {STAGES{RESET_VAL}};
         else        r <= {r[STAGES-2:0], d_i};
      end
      assign q_o = r[STAGES-1];
   end
endmodule

// File: rtl/ab_echo_tx.sv
module ab_echo_tx #(
   parameter int BT_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_i,
   input  logic [BT_W-1:0] bit_time_i,
   input  logic [7:0]      first_i,
   input  logic [7:0]      second_i,
   output logic            line_o,
   output logic            busy_o
);
   localparam int FRAME_W = 20;
   localparam int IDX_W   = $clog2(FRAME_W);

   logic [FRAME_W-1:0] frame;
   logic [IDX_W-1:0]   idx;
   logic [BT_W-1:0]    tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame  <= '1;
         idx    <= '0;
         tmr    <= '0;
         busy_o <= 1'b0;
      end else if (go_i) begin
         frame  <= {1'b1, second_i, 1'b0, 1'b1, first_i, 1'b0};
         idx    <= '0;
         tmr    <= bit_time_i - BT_W'(1);
         busy_o <= 1'b1;
      end else if (busy_o) begin
         if (tmr != '0) begin
            tmr <= tmr - BT_W'(1);
         end else begin
            frame <= {1'b1, frame[FRAME_W-1:1]};
            tmr   <= bit_time_i - BT_W'(1);
            idx   <= idx + IDX_W'(1);
            if (idx == IDX_W'(FRAME_W-1)) busy_o <= 1'b0;
         end
      end
   end

   assign line_o = busy_o ? frame[0] : 1'b1;
endmodule

// File: rtl/autobaud_det.sv
module autobaud_det
   import ab_pkg::*;
#(
   parameter int DIV_W       = 10,
   parameter int OVS_LOG2    = 4,
   parameter int CNT_W       = 14,
   parameter int MIN_W       = 16,
   parameter int GAP_BITS    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_i,
   input  logic             uart_tx_i,
   input  logic             arm_i,
   input  logic             prog_en_i,
   input  logic             echo_en_i,
   input  logic             irq_en_i,
   input  logic             irq_ack_i,
   output logic             tx_o,
   output logic [DIV_W-1:0] baud_div_o,
   output logic             baud_we_o,
   output logic             rx_en_o,
   output logic             irq_o
);
   localparam int OVS      = 1 << OVS_LOG2;
   localparam int BT_W     = DIV_W + OVS_LOG2;
   localparam int ABORT_AT = ((1 << DIV_W) - 1) * OVS + OVS / 2 - 1;
   localparam int NB_MAX   = (GAP_BITS > 10) ? GAP_BITS : 10;
   localparam int NB_W     = $clog2(NB_MAX + 1);

   if (OVS_LOG2 < 1) begin : g_bad_ovs
      $error("autobaud_det: OVS_LOG2 must be at least 1");
   end
   if (CNT_W < BT_W) begin : g_bad_cnt
      $error("autobaud_det: CNT_W must cover DIV_W + OVS_LOG2");
   end
   if (MIN_W < OVS / 2 || MIN_W >= ABORT_AT) begin : g_bad_min
      $error("autobaud_det: MIN_W out of range");
   end
   if (GAP_BITS < 1) begin : g_bad_gap
      $error("autobaud_det: GAP_BITS must be positive");
   end

   ab_state_t         st;
   logic              rx_s, rx_q, arm_q, arm_rise, fall;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W:0]    cnt_rnd;
   logic [DIV_W-1:0]  div_calc, div_r;
   logic [BT_W-1:0]   half_calc, half_r, bt_r, tmr;
   logic [NB_W-1:0]   bitn;
   logic [9:1]        shreg;
   logic [7:0]        dat, c1_r, c2_r;
   logic              ok1, ok2, irq_flag, echo_go;
   logic              echo_line, echo_busy;

   ab_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rx_sync (
      .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
   );

   assign fall      = rx_q & ~rx_s;
   assign arm_rise  = arm_i & ~arm_q;
   assign cnt_rnd   = {1'b0, cnt} + (CNT_W+1)'(OVS / 2);
   assign div_calc  = DIV_W'(cnt_rnd >> OVS_LOG2);
   assign half_calc = BT_W'(div_calc) << (OVS_LOG2 - 1);
   assign half_r    = BT_W'(div_r) << (OVS_LOG2 - 1);
   assign bt_r      = BT_W'(div_r) << OVS_LOG2;
   assign dat       = shreg[9:2];
   assign ok1       = rx_s && (dat == FIRST_UP || dat == FIRST_LO);
   assign ok2       = rx_s && !shreg[1] &&
                      ((c1_r == FIRST_UP && dat == SECOND_UP) ||
                       (c1_r == FIRST_LO && dat == SECOND_LO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_OFF;
         rx_q       <= 1'b1;
         arm_q      <= 1'b0;
         cnt        <= '0;
         div_r      <= '0;
         tmr        <= '0;
         bitn       <= '0;
         shreg      <= '0;
         c1_r       <= '0;
         c2_r       <= '0;
         baud_div_o <= '0;
         baud_we_o  <= 1'b0;
         rx_en_o    <= 1'b0;
         irq_flag   <= 1'b0;
         echo_go    <= 1'b0;
      end else begin
         rx_q      <= rx_s;
         arm_q     <= arm_i;
         baud_we_o <= 1'b0;
         echo_go   <= 1'b0;
         if (irq_ack_i) irq_flag <= 1'b0;
         if (arm_rise)  rx_en_o  <= 1'b0;
         if (!arm_i) begin
            st <= ST_OFF;
         end else begin
            unique case (st)
               ST_OFF: st <= ST_HUNT;
               ST_HUNT: begin
                  if (fall) begin
                     cnt <= CNT_W'(1);
                     st  <= ST_MEAS;
                  end
               end
               ST_MEAS: begin
                  if (rx_s) begin
                     if (cnt < CNT_W'(MIN_W)) begin
                        st <= ST_HUNT;
                     end else begin
                        div_r <= div_calc;
                        tmr   <= half_calc - BT_W'(1);
                        bitn  <= '0;
                        st    <= ST_CHAR1;
                     end
                  end else if (cnt == CNT_W'(ABORT_AT)) begin
                     st <= ST_HUNT;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               ST_CHAR1, ST_CHAR2: begin
                  if (tmr != '0) begin
                     tmr <= tmr - BT_W'(1);
                  end else begin
                     shreg <= {rx_s, shreg[9:2]};
                     tmr   <= bt_r - BT_W'(1);
                     bitn  <= bitn + NB_W'(1);
                     if (st == ST_CHAR1 && bitn == NB_W'(8)) begin
                        bitn <= '0;
                        if (ok1) begin
                           c1_r <= dat;
                           st   <= ST_GAP;
                        end else begin
                           st <= ST_HUNT;
                        end
                     end
                     if (st == ST_CHAR2 && bitn == NB_W'(9)) begin
                        if (ok2) begin
                           c2_r       <= dat;
                           baud_div_o <= div_r;
                           baud_we_o  <= prog_en_i;
                           if (prog_en_i) rx_en_o <= 1'b1;
                           irq_flag   <= 1'b1;
                           echo_go    <= echo_en_i;
                           st         <= ST_DONE;
                        end else begin
                           st <= ST_HUNT;
                        end
                     end
                  end
               end
               ST_GAP: begin
                  if (fall) begin
                     tmr  <= half_r - BT_W'(1);
                     bitn <= '0;
                     st   <= ST_CHAR2;
                  end else if (tmr == '0) begin
                     tmr  <= bt_r - BT_W'(1);
                     bitn <= bitn + NB_W'(1);
                     if (bitn == NB_W'(GAP_BITS - 1)) st <= ST_HUNT;
                  end else begin
                     tmr <= tmr - BT_W'(1);
                  end
               end
               default: st <= ST_DONE;
            endcase
         end
      end
   end

   ab_echo_tx #(.BT_W(BT_W)) u_echo (
      .clk(clk), .rst_n(rst_n), .go_i(echo_go),
      .bit_time_i(BT_W'(baud_div_o) << OVS_LOG2),
      .first_i(c1_r), .second_i(c2_r),
      .line_o(echo_line), .busy_o(echo_busy)
   );

   assign tx_o  = echo_busy ? echo_line : uart_tx_i;
   assign irq_o = irq_flag & irq_en_i;
endmodule

// File: rtl/autobaud_det_chk.sv
module autobaud_det_chk
   import ab_pkg::*;
#(
   parameter int DIV_W    = 10,
   parameter int CNT_W    = 14,
   parameter int ABORT_AT = 16375
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm_i,
   input logic             irq_en_i,
   input logic             uart_tx_i,
   input logic             tx_o,
   input logic [DIV_W-1:0] baud_div_o,
   input logic             baud_we_o,
   input logic             irq_o,
   input logic             irq_flag,
   input logic             echo_busy,
   input ab_state_t        st,
   input logic [CNT_W-1:0] cnt
);
   // R3
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      baud_we_o |=> !baud_we_o);
   // R2
   div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      baud_we_o |-> (baud_div_o != '0));
   // R8
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> irq_en_i);
   // R7
   tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_o != uart_tx_i) |-> echo_busy);
   // R6
   meas_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MEAS) |-> (cnt <= CNT_W'(ABORT_AT)));
   // R9
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_i |=> (st == ST_OFF));
   // R4
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> ($past(st) == ST_CHAR2));
endmodule

bind autobaud_det autobaud_det_chk #(
   .DIV_W(DIV_W), .CNT_W(CNT_W), .ABORT_AT(ABORT_AT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .irq_en_i(irq_en_i),
   .uart_tx_i(uart_tx_i), .tx_o(tx_o), .baud_div_o(baud_div_o),
   .baud_we_o(baud_we_o), .irq_o(irq_o), .irq_flag(irq_flag),
   .echo_busy(echo_busy), .st(st), .cnt(cnt)
);

// File: tb/autobaud_det_tb_top.sv
module autobaud_det_tb_top;
   localparam int DIV_W = 10;

   logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, utx = 1'b1;
   logic arm = 1'b0, prog = 1'b0, echo = 1'b0, irq_en = 1'b0, ack = 1'b0;
   logic tx, baud_we, rx_en, irq;
   logic [DIV_W-1:0] baud_div;

   int n_chk = 0, n_fail = 0, we_cnt = 0, pass_err = 0, irq_err = 0, cyc = 0;
   logic toggle_on = 1'b1;
   logic [19:0] got;

   always #4 clk = ~clk;

   autobaud_det dut_i (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .uart_tx_i(utx), .arm_i(arm),
      .prog_en_i(prog), .echo_en_i(echo), .irq_en_i(irq_en), .irq_ack_i(ack),
      .tx_o(tx), .baud_div_o(baud_div), .baud_we_o(baud_we), .rx_en_o(rx_en),
      .irq_o(irq)
   );

   // per-clock reference observations
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (baud_we) we_cnt++;
         if (!echo && tx !== utx) pass_err++;
         if (irq && !irq_en) irq_err++;
      end
   end

   // independent activity on the port's own transmit line
   initial begin
      forever begin
         @(posedge clk); #1;
         if (!toggle_on) utx = 1'b1;
         else if (cyc % 37 == 0) utx = ~utx;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input int bt);
      rx = 1'b0; idle(bt);
      for (int i = 0; i < 8; i++) begin rx = b[i]; idle(bt); end
      rx = 1'b1; idle(bt);
   endtask

   task automatic send_pair(input logic [7:0] c1, input logic [7:0] c2, input int bt);
      send_byte(c1, bt); idle(2 * bt); send_byte(c2, bt); idle(4 * bt);
   endtask

   task automatic rearm();
      arm = 1'b0; idle(3); arm = 1'b1; idle(3);
   endtask

   task automatic ack_irq();
      ack = 1'b1; idle(1); ack = 1'b0; idle(1);
   endtask

   function automatic int xdiv(input int n);
      return (n + 8) / 16;
   endfunction

   task automatic expect_det(input string req, input int bt, input int we0);
      chk(we_cnt == we0 + 1, {req, " write strobe count"}, we_cnt, we0 + 1);
      chk(int'(baud_div) == xdiv(bt), {req, " divisor"}, int'(baud_div), xdiv(bt));
   endtask

   task automatic cap_echo(input int bt, output logic [19:0] g);
      int t = 0;
      g = '0;
      while (tx !== 1'b0 && t < 60000) begin idle(1); t++; end
      idle(bt / 2);
      for (int i = 0; i < 20; i++) begin g[i] = tx; idle(bt); end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int w0;
      idle(5); rst_n = 1'b1; idle(2);
      // R1 reset state
      chk(rx_en == 1'b0, "R1 rx_en", int'(rx_en), 0);
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);
      chk(baud_we == 1'b0, "R1 we", int'(baud_we), 0);
      chk(tx === utx, "R1 tx follows", int'(tx), int'(utx));

      prog = 1'b1; irq_en = 1'b1; arm = 1'b1; idle(3);
      // R2 R3 basic detection at 128 clocks per bit
      w0 = we_cnt; send_pair(8'h41, 8'h54, 128);
      expect_det("R2", 128, w0);
      chk(rx_en == 1'b1, "R3 rx_en set", int'(rx_en), 1);
      chk(irq == 1'b1, "R8 irq set", int'(irq), 1);
      ack_irq();
      chk(irq == 1'b0, "R8 irq cleared", int'(irq), 0);

      // R9 ignored after detection
      w0 = we_cnt; send_pair(8'h41, 8'h54, 160);
      chk(we_cnt == w0, "R9 no strobe when done", we_cnt, w0);
      chk(int'(baud_div) == 8, "R9 divisor kept", int'(baud_div), 8);

      // R3 rearm clears rx_en, R4 lower case pair
      rearm();
      chk(rx_en == 1'b0, "R3 rx_en cleared", int'(rx_en), 0);
      w0 = we_cnt; send_pair(8'h61, 8'h74, 160);
      expect_det("R4 lower case", 160, w0);
      ack_irq();

      // R9 disarmed
      arm = 1'b0; idle(3);
      w0 = we_cnt; send_pair(8'h41, 8'h54, 128);
      chk(we_cnt == w0, "R9 disarmed", we_cnt, w0);
      arm = 1'b1; idle(3);

      // R5 glitch then slow rate
      rx = 1'b0; idle(10); rx = 1'b1; idle(50);
      w0 = we_cnt; send_pair(8'h41, 8'h54, 600);
      expect_det("R5 after glitch", 600, w0);
      ack_irq();

      // R4 mismatched pairs
      rearm();
      w0 = we_cnt; send_pair(8'h41, 8'h58, 160); idle(20 * 160);
      send_pair(8'h61, 8'h54, 160); idle(20 * 160);
      chk(we_cnt == w0, "R4 mismatch rejected", we_cnt, w0);
      chk(irq == 1'b0, "R4 no irq on mismatch", int'(irq), 0);
      send_pair(8'h41, 8'h54, 160);
      expect_det("R4 after mismatch", 160, w0);
      ack_irq();

      // R6 overflow abort then rearm
      rearm();
      w0 = we_cnt; rx = 1'b0; idle(17000); rx = 1'b1; idle(100);
      chk(we_cnt == w0, "R6 no detect on overflow", we_cnt, w0);
      send_pair(8'h41, 8'h54, 128);
      expect_det("R6 after overflow", 128, w0);
      ack_irq();

      // R10 missing second character
      rearm();
      w0 = we_cnt; send_byte(8'h41, 128); idle(30 * 128);
      chk(we_cnt == w0, "R10 lone first char", we_cnt, w0);
      send_pair(8'h41, 8'h54, 128);
      expect_det("R10 after timeout", 128, w0);
      ack_irq();

      // R3 programming disabled, R2 divisor still reported
      rearm(); prog = 1'b0;
      w0 = we_cnt; send_pair(8'h41, 8'h54, 192);
      chk(we_cnt == w0, "R3 no strobe without prog", we_cnt, w0);
      chk(rx_en == 1'b0, "R3 rx_en stays off", int'(rx_en), 0);
      chk(int'(baud_div) == xdiv(192), "R2 divisor without prog", int'(baud_div), xdiv(192));
      chk(irq == 1'b1, "R8 irq without prog", int'(irq), 1);
      ack_irq(); prog = 1'b1;

      // R8 masked interrupt stays pending
      rearm(); irq_en = 1'b0;
      w0 = we_cnt; send_pair(8'h41, 8'h54, 160);
      chk(irq == 1'b0, "R8 masked", int'(irq), 0);
      irq_en = 1'b1; idle(1);
      chk(irq == 1'b1, "R8 pending shown", int'(irq), 1);
      ack_irq();

      // R7 echo at new rate
      toggle_on = 1'b0; idle(4); echo = 1'b1;
      rearm();
      fork
         send_pair(8'h41, 8'h54, 128);
         cap_echo(128, got);
      join
      chk(got == {1'b1, 8'h54, 1'b0, 1'b1, 8'h41, 1'b0}, "R7 echo AT", int'(got),
          int'({1'b1, 8'h54, 1'b0, 1'b1, 8'h41, 1'b0}));
      rearm();
      fork
         send_pair(8'h61, 8'h74, 160);
         cap_echo(160, got);
      join
      chk(got == {1'b1, 8'h74, 1'b0, 1'b1, 8'h61, 1'b0}, "R7 echo at", int'(got),
          int'({1'b1, 8'h74, 1'b0, 1'b1, 8'h61, 1'b0}));
      idle(200);
      chk(tx === 1'b1, "R7 idle after echo", int'(tx), 1);
      echo = 1'b0; toggle_on = 1'b1; idle(100);

      // per-clock observations
      chk(pass_err == 0, "R7 tx passthrough every clock", pass_err, 0);
      chk(irq_err == 0, "R8 mask every clock", irq_err, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule